// File: doc/BRIEF.md
# Variable-Length Codeword Byte Packer

This block joins a stream of short codewords, each between one and eight bits long, into a dense stream of bytes. Every input beat carries a code value and a length. The packer appends exactly that many bits to what it already holds, so no filler bits sit between neighbouring codewords. A beat of any legal length is absorbed in a single clock. As soon as eight bits are available, a complete byte is handed to a one-entry output register that uses a valid/ready handshake.

An entropy coder drives the block one codeword per cycle. At the end of a segment it sends a flush beat on the same handshake. The flush pads the leftover bits (fewer than eight) with a fill value up to a byte boundary and emits that byte, after which the packer starts the next segment empty. When the consumer stalls, the packer keeps taking codewords for as long as none of them would complete a byte. It lowers its input ready only when a byte would have nowhere to go.

Top module: `vlc_byte_packer`

## Requirements
- R1: After reset `out_valid` is 0, the residue is empty and `in_ready` is 1.
- R2: Bits leave MSB-first. Within a codeword, `in_code[in_len-1]` is sent first and `in_code[0]` last. The first bit of each codeword directly follows the last bit of the previous one, and the first bit of the stream lands in `out_data[7]`.
- R3: Only the low `in_len` bits of `in_code` are used. Bits at or above position `in_len` have no effect on the output.
- R4: On a code beat (`in_valid`=1, `flush`=0), `in_len` is an unsigned binary count in the range 1 to 8.
- R5: While `out_ready` is 1, `in_ready` stays 1, so one codeword of any legal length is accepted on every clock.
- R6: A flush beat (`in_valid`=1, `flush`=1) with a non-empty residue emits one byte. That byte holds the residue bits at its MSB end and zero fill below them (default fill). The residue is then empty. `in_code` and `in_len` are ignored on flush beats.
- R7: A flush beat with an empty residue is accepted and produces no byte.
- R8: While `out_valid`=1 and `out_ready`=0, a code beat is accepted only if the residue count plus `in_len` is below 8, and a flush beat only if the residue is empty. Otherwise `in_ready` is 0.
- R9: While `out_valid`=1 and `out_ready`=0, `out_valid` and `out_data` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Input beat is taken at this clock edge |
| flush | input | 1 | Qualifies the beat as a flush instead of a codeword |
| in_len | input | 4 | Codeword length in bits (1 to 8) |
| in_code | input | 8 | Codeword value, right-aligned |
| out_valid | output | 1 | A packed byte is held on `out_data` |
| out_ready | input | 1 | Consumer takes the byte at this clock edge |
| out_data | output | 8 | Packed byte, first stream bit in bit 7 |

## Verification
The corner cases the bench targets are:
- **Codeword splits across a byte boundary, and full-length codewords.** A packer that mis-aligns its shift would rotate or drop bits at the seam.
- **Junk above the stated length.** A missing mask would OR that junk into earlier bit positions.
- **Two flushes in a row.** A packer that pads an empty residue would emit a spurious all-zero byte.
- **Consumer stalled while codewords keep arriving.** A design that ignores back-pressure would overwrite the held byte, and one that is too cautious would stall codewords that fit in the residue.

A long random run with a toggling `out_ready` checks every byte against a bit-queue model of the stream.

// File: rtl/vlc_pack_pkg.sv
`timescale 1ns/1ps
package vlc_pack_pkg;

   // Kind of work performed for the beat on the input port in one cycle.
   typedef enum logic [1:0] {
      PK_IDLE  = 2'd0,
      PK_CODE  = 2'd1,
      PK_FLUSH = 2'd2
   } pk_action_e;

   // Bits needed to count 0..n inclusive.
   function automatic int pk_count_w(input int n);
      return $clog2(n + 1);
   endfunction

endpackage

// File: rtl/vlc_code_mask.sv
`timescale 1ns/1ps
// Clears every code bit at or above the stated length.
module vlc_code_mask #(
   parameter int MAX_LEN = 8,
   parameter int LEN_W   = 4
) (
   input  logic [MAX_LEN-1:0] code_i,
   input  logic [LEN_W-1:0]   len_i,
   output logic [MAX_LEN-1:0] code_o
);

   for (genvar b = 0; b < MAX_LEN; b++) begin : g_bit
      assign code_o[b] = code_i[b] & (len_i > LEN_W'(b));
   end

endmodule

// File: rtl/vlc_merge_window.sv
`timescale 1ns/1ps
// Places a masked codeword right behind the left-aligned residue and splits
// the result into an outgoing byte and the new residue. Also forms the
// padded byte used by a flush.
module vlc_merge_window #(
   parameter int BYTE_W   = 8,
   parameter int MAX_LEN  = 8,
   parameter bit PAD_ONES = 1'b0,
   localparam int RES_W   = BYTE_W - 1,
   localparam int CNT_W   = $clog2(BYTE_W),
   localparam int LEN_W   = vlc_pack_pkg::pk_count_w(MAX_LEN)
) (
   input  logic [RES_W-1:0]  res_i,
   input  logic [CNT_W-1:0]  cnt_i,
   input  logic [MAX_LEN-1:0] code_i,
   input  logic [LEN_W-1:0]  len_i,
   output logic              emit_o,
   output logic [BYTE_W-1:0] byte_o,
   output logic [RES_W-1:0]  res_o,
   output logic [CNT_W-1:0]  cnt_o,
   output logic [BYTE_W-1:0] flush_byte_o
);

   localparam int WIN_W = RES_W + MAX_LEN;
   localparam int SUM_W = vlc_pack_pkg::pk_count_w(WIN_W);

   logic [SUM_W-1:0] total;
   logic [SUM_W-1:0] shamt;
   logic [WIN_W-1:0] base;
   logic [WIN_W-1:0] placed;
   logic [WIN_W-1:0] win;
   logic [WIN_W-1:0] win_sh;

   always_comb begin
      total  = SUM_W'(cnt_i) + SUM_W'(len_i);
      shamt  = SUM_W'(WIN_W) - total;
      base   = {res_i, {MAX_LEN{1'b0}}};
      placed = WIN_W'(code_i) << shamt;
      win    = base | placed;
      win_sh = win << BYTE_W;
      emit_o = (total >= SUM_W'(BYTE_W));
      byte_o = win[WIN_W-1 -: BYTE_W];
      if (emit_o) begin
         res_o = win_sh[WIN_W-1 -: RES_W];
         cnt_o = CNT_W'(total - SUM_W'(BYTE_W));
      end else begin
         res_o = win[WIN_W-1 -: RES_W];
         cnt_o = CNT_W'(total);
      end
   end

   // Fill variant picked at elaboration.
   if (PAD_ONES) begin : g_fill_one
      logic [BYTE_W-1:0] fill;
      assign fill         = {BYTE_W{1'b1}} >> cnt_i;
      assign flush_byte_o = {res_i, 1'b0} | fill;
   end else begin : g_fill_zero
      assign flush_byte_o = {res_i, 1'b0};
   end

endmodule

// File: rtl/vlc_out_slot.sv
`timescale 1ns/1ps
// One-entry output register with a valid/ready handshake.
module vlc_out_slot #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [BYTE_W-1:0] data_i,
   input  logic              ready_i,
   output logic              valid_o,
   output logic [BYTE_W-1:0] data_o,
   output logic              free_o
);

   assign free_o = !valid_o || ready_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         data_o  <= '0;
      end else if (load_i) begin
         valid_o <= 1'b1;
         data_o  <= data_i;
      end else if (ready_i) begin
         valid_o <= 1'b0;
      end
   end

endmodule

// File: rtl/vlc_byte_packer.sv
`timescale 1ns/1ps
module vlc_byte_packer #(
   parameter int BYTE_W   = 8,
   parameter int MAX_LEN  = 8,
   parameter bit PAD_ONES = 1'b0,
   localparam int LEN_W   = vlc_pack_pkg::pk_count_w(MAX_LEN)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   output logic               in_ready,
   input  logic               flush,
   input  logic [LEN_W-1:0]   in_len,
   input  logic [MAX_LEN-1:0] in_code,
   output logic               out_valid,
   input  logic               out_ready,
   output logic [BYTE_W-1:0]  out_data
);

   import vlc_pack_pkg::*;

   localparam int RES_W = BYTE_W - 1;
   localparam int CNT_W = $clog2(BYTE_W);

   if (BYTE_W < 2) begin : g_bad_byte
      $error("vlc_byte_packer: BYTE_W must be at least 2");
   end
   if (MAX_LEN < 1 || MAX_LEN > BYTE_W) begin : g_bad_len
      $error("vlc_byte_packer: MAX_LEN must lie in 1..BYTE_W");
   end

   logic [RES_W-1:0]   res_q;
   logic [CNT_W-1:0]   res_cnt;
   logic [MAX_LEN-1:0] code_m;
   logic               m_emit;
   logic [BYTE_W-1:0]  m_byte;
   logic [RES_W-1:0]   m_res;
   logic [CNT_W-1:0]   m_cnt;
   logic [BYTE_W-1:0]  f_byte;
   logic               slot_free;
   logic               slot_load;
   logic [BYTE_W-1:0]  slot_data;
   logic               res_empty;
   pk_action_e         act;

   vlc_code_mask #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_mask (
      .code_i (in_code),
      .len_i  (in_len),
      .code_o (code_m)
   );

   vlc_merge_window #(.BYTE_W(BYTE_W), .MAX_LEN(MAX_LEN), .PAD_ONES(PAD_ONES)) u_win (
      .res_i        (res_q),
      .cnt_i        (res_cnt),
      .code_i       (code_m),
      .len_i        (in_len),
      .emit_o       (m_emit),
      .byte_o       (m_byte),
      .res_o        (m_res),
      .cnt_o        (m_cnt),
      .flush_byte_o (f_byte)
   );

   vlc_out_slot #(.BYTE_W(BYTE_W)) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (slot_load),
      .data_i  (slot_data),
      .ready_i (out_ready),
      .valid_o (out_valid),
      .data_o  (out_data),
      .free_o  (slot_free)
   );

   assign res_empty = (res_cnt == '0);

   always_comb begin
      if (flush) in_ready = slot_free || res_empty;
      else       in_ready = slot_free || !m_emit;

      act = PK_IDLE;
      if (in_valid && in_ready) act = flush ? PK_FLUSH : PK_CODE;

      slot_load = 1'b0;
      slot_data = m_byte;
      case (act)
         PK_CODE:  slot_load = m_emit;
         PK_FLUSH: begin
            slot_load = !res_empty;
            slot_data = f_byte;
         end
         default:  slot_load = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_q   <= '0;
         res_cnt <= '0;
      end else begin
         case (act)
            PK_CODE: begin
               res_q   <= m_res;
               res_cnt <= m_cnt;
            end
            PK_FLUSH: begin
               res_q   <= '0;
               res_cnt <= '0;
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/vlc_byte_packer_chk.sv
`timescale 1ns/1ps
module vlc_byte_packer_chk #(
   parameter int BYTE_W  = 8,
   parameter int MAX_LEN = 8,
   parameter int LEN_W   = 4,
   parameter int CNT_W   = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_ready,
   input logic              flush,
   input logic [LEN_W-1:0]  in_len,
   input logic              out_valid,
   input logic              out_ready,
   input logic [BYTE_W-1:0] out_data,
   input logic [CNT_W-1:0]  res_cnt
);

   // R9
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

   // R6
   flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && flush && in_ready) |=> (res_cnt == '0));

   // R7
   empty_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && flush && in_ready && res_cnt == '0 && (!out_valid || out_ready))
      |=> !out_valid);

   // R8
   backpress_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_ready |-> (out_valid && !out_ready));

   // R5
   throughput_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_ready |-> in_ready);

   // R4
   len_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !flush) |-> (in_len >= LEN_W'(1) && in_len <= LEN_W'(MAX_LEN)));

endmodule

bind vlc_byte_packer vlc_byte_packer_chk #(
   .BYTE_W  (BYTE_W),
   .MAX_LEN (MAX_LEN),
   .LEN_W   (LEN_W),
   .CNT_W   ($clog2(BYTE_W))
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .flush     (flush),
   .in_len    (in_len),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_data  (out_data),
   .res_cnt   (res_cnt)
);

// File: tb/vlc_byte_packer_tb.sv
`timescale 1ns/1ps
module vlc_byte_packer_tb;

   localparam int CLK_NS = 8;
   localparam int NTAB   = 12;
   localparam int NEXP   = 6;

   // {flush, len[3:0], code[7:0]}
   localparam logic [12:0] STIM [NTAB] = '{
      {1'b0, 4'd3, 8'h05}, {1'b0, 4'd5, 8'h13}, {1'b0, 4'd1, 8'hFE},
      {1'b0, 4'd8, 8'h81}, {1'b0, 4'd7, 8'h36}, {1'b0, 4'd2, 8'hA7},
      {1'b1, 4'd0, 8'h00}, {1'b1, 4'd0, 8'h00}, {1'b0, 4'd4, 8'hF5},
      {1'b0, 4'd4, 8'h0A}, {1'b0, 4'd6, 8'h38}, {1'b1, 4'd8, 8'hFF}
   };
   localparam logic [7:0] EXPB [NEXP] = '{8'hB3, 8'h40, 8'hB6, 8'hC0, 8'h5A, 8'hE0};

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic       in_ready;
   logic       flush = 1'b0;
   logic [3:0] in_len = '0;
   logic [7:0] in_code = '0;
   logic       out_valid;
   logic       out_ready = 1'b0;
   logic [7:0] out_data;

   int n_chk = 0;
   int n_bad = 0;
   int stalls = 0;
   bit done = 1'b0;
   bit rnd_phase = 1'b0;
   bit        bitq[$];
   logic [7:0] expq[$];
   logic [7:0] obsq[$];

   always #(CLK_NS/2) clk = ~clk;

   vlc_byte_packer u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .flush(flush), .in_len(in_len), .in_code(in_code),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   // Reference bit-queue model (R2 ordering, R3 mask, R6/R7 flush).
   task automatic model_take(input bit fl, input logic [3:0] len, input logic [7:0] code);
      logic [7:0] b;
      if (fl) begin
         if (bitq.size() > 0) while (bitq.size() < 8) bitq.push_back(1'b0);
      end else begin
         for (int i = int'(len) - 1; i >= 0; i--) bitq.push_back(code[i]);
      end
      while (bitq.size() >= 8) begin
         for (int i = 7; i >= 0; i--) b[i] = bitq.pop_front();
         expq.push_back(b);
      end
   endtask

   task automatic send(input bit fl, input logic [3:0] len, input logic [7:0] code);
      @(negedge clk);
      in_valid = 1'b1; flush = fl; in_len = len; in_code = code;
      #3;
      while (!in_ready) begin
         stalls++;
         @(negedge clk);
         #3;
      end
      model_take(fl, len, code);
      @(posedge clk);
      #1 in_valid = 1'b0;
   endtask

   task automatic probe(input bit fl, input logic [3:0] len, input logic [7:0] code,
                        input bit exp_rdy);
      @(negedge clk);
      in_valid = 1'b1; flush = fl; in_len = len; in_code = code;
      #3;
      chk(in_ready == exp_rdy, "R8 in_ready under stall", int'(in_ready), int'(exp_rdy));
      if (in_ready) model_take(fl, len, code);
      @(posedge clk);
      #1 in_valid = 1'b0;
   endtask

   // Output monitor: compares each handed-over byte with the model (R2, R3, R6).
   initial begin
      forever begin
         @(negedge clk);
         #3;
         if (rst_n && out_valid && out_ready) begin
            obsq.push_back(out_data);
            if (expq.size() == 0) begin
               chk(1'b0, "R7 unexpected byte", int'(out_data), -1);
            end else begin
               logic [7:0] e;
               e = expq.pop_front();
               chk(out_data == e, "R2 byte order", int'(out_data), int'(e));
            end
         end
      end
   end

   // Random back-pressure during the random phase.
   initial begin
      forever begin
         @(negedge clk);
         if (rnd_phase) out_ready = (($urandom % 10) < 7);
      end
   end

   initial begin
      #(CLK_NS * 150000);
      chk(1'b0, "watchdog", 0, 1);
      finish_run();
   end

   initial begin
      void'($urandom(32'h5EED));
      // R1: reset state
      repeat (3) @(posedge clk);
      #3;
      chk(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
      chk(in_ready == 1'b1, "R1 in_ready in reset", int'(in_ready), 1);
      @(negedge clk) rst_n = 1'b1;
      out_ready = 1'b1;

      // Table walk: R2 packing, R3 junk bits, R6 flush pad, R7 empty flush, R5 no stall
      stalls = 0;
      for (int t = 0; t < NTAB; t++) send(STIM[t][12], STIM[t][11:8], STIM[t][7:0]);
      repeat (4) @(negedge clk);
      chk(stalls == 0, "R5 stall cycles", stalls, 0);
      chk(obsq.size() == NEXP, "R7 byte count", obsq.size(), NEXP);
      for (int k = 0; k < NEXP; k++) begin
         if (k < obsq.size())
            chk(obsq[k] == EXPB[k], "R2 table byte", int'(obsq[k]), int'(EXPB[k]));
      end

      // Directed stall: R8 acceptance and R9 hold
      @(negedge clk) out_ready = 1'b0;
      send(1'b0, 4'd8, 8'h96);
      send(1'b0, 4'd3, 8'hFD);
      send(1'b0, 4'd4, 8'h0C);
      probe(1'b0, 4'd2, 8'h01, 1'b0);
      probe(1'b1, 4'd0, 8'h00, 1'b0);
      @(negedge clk);
      #3 chk(out_valid && out_data == 8'h96, "R9 held byte", int'(out_data), 8'h96);
      @(negedge clk);
      #3 chk(out_valid && out_data == 8'h96, "R9 held byte", int'(out_data), 8'h96);
      @(negedge clk) out_ready = 1'b1;
      send(1'b0, 4'd2, 8'hFD);
      send(1'b1, 4'd5, 8'h1F);
      repeat (4) @(negedge clk);
      chk(expq.size() == 0, "R6 flush drained", expq.size(), 0);

      // Random phase with toggling out_ready
      rnd_phase = 1'b1;
      for (int n = 0; n < 3000; n++) begin
         logic [3:0] l;
         l = 4'(1 + ($urandom % 8));
         send(($urandom % 20) == 0, l, 8'($urandom));
      end
      send(1'b1, 4'd0, 8'h00);
      rnd_phase = 1'b0;
      @(negedge clk) out_ready = 1'b1;
      repeat (6) @(negedge clk);
      chk(expq.size() == 0, "R2 all bytes delivered", expq.size(), 0);
      finish_run();
   end

endmodule